// File: doc/BRIEF.md
# Lane-Partitioned Vector ALU

The block treats two wide operand vectors as arrays of equal-sized lanes. The lane width is chosen for each operation and can be any power of two from a single bit up to the full vector. One elementwise operation is applied to every pair of matching lanes: add, subtract, bitwise AND, OR or XOR, or a logical right shift by an immediate amount. Each lane is computed on its own. Carries, borrows and shifted-out bits never reach a neighbouring lane.

An operation is presented with `in_valid` high, and its result appears one clock later with `out_valid` high. There is no back-pressure. Very narrow lanes (1, 2 and 4 bits) use the same datapath as byte and word lanes, so bit-level counting and parity steps can run on the same unit.

Top module: `lane_alu`

## Requirements
- R1: `width_sel` holds k (0 to 7), and the lane width is n = 2^k bits: 1, 2, 4, 8, 16, 32, 64 or 128. Lane i occupies bits [i*n+n-1 : i*n].
- R2: Opcode 0 (add) sets each result lane to (a_i + b_i) mod 2^n. No carry passes into the next lane up.
- R3: Opcode 1 (subtract) sets each result lane to (a_i - b_i) mod 2^n. No borrow passes between lanes.
- R4: Opcodes 2, 3 and 4 give bitwise AND, OR and XOR of the operands at every lane width.
- R5: Opcode 5 shifts each lane of `opnd_a` right by `shift_amt`, filling the top of the lane with zeros. No bit moves in from the lane above. `opnd_b` is ignored.
- R6: A shift amount equal to or greater than the lane width gives a zero lane.
- R7: At lane width 1, both add and subtract give a ^ b.
- R8: `out_valid` equals `in_valid` from the previous clock. `result` is loaded only in a cycle where `in_valid` is high, and it holds its value otherwise.
- R9: While `rst_n` is low, `out_valid` and `result` are zero.
- R10: Opcodes 6 and 7 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code |
| width_sel | input | 3 | Lane width exponent k |
| shift_amt | input | 8 | Right shift distance for opcode 5 |
| opnd_a | input | 128 | First operand vector |
| opnd_b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered lane-wise result |

## Verification
The bench builds the block with its default 128-bit vector. At that size all eight lane widths can be reached, from single-bit lanes up to one lane spanning the whole vector. It also allows shift amounts beyond the widest lane, up to 255. Every result is compared with a per-lane reference loop, using directed carry and borrow chains that run across every lane boundary and pseudo-random operands at each width and opcode.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SRL = 3'd5
  } alu_op_e;
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
  parameter int VEC_W  = 128,
  parameter int LOG_W  = $clog2(VEC_W),
  parameter int IDX_W  = LOG_W + 1,
  parameter int WSEL_W = $clog2(LOG_W + 1)
) (
  input  logic [WSEL_W-1:0] width_sel,
  output logic [IDX_W-1:0]  low_mask,
  output logic [VEC_W-1:0]  lane_start
);
  // low_mask = lane width - 1, used to find a bit's position inside its lane
  always_comb begin
    low_mask = IDX_W'((IDX_W'(1) << width_sel) - IDX_W'(1));
  end

  for (genvar i = 0; i < VEC_W; i++) begin : g_start
    assign lane_start[i] = ((IDX_W'(i) & low_mask) == '0);
  end
endmodule

// File: rtl/lane_addsub.sv
module lane_addsub #(
  parameter int VEC_W = 128
) (
  input  logic             sub,
  input  logic [VEC_W-1:0] lane_start,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] sum
);
  always_comb begin
    logic c;
    logic bx;
    logic cin;
    c = 1'b0;
    for (int i = 0; i < VEC_W; i++) begin
      bx     = b[i] ^ sub;
      cin    = lane_start[i] ? sub : c;
      sum[i] = a[i] ^ bx ^ cin;
      c      = (a[i] & bx) | (a[i] & cin) | (bx & cin);
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int VEC_W = 128,
  parameter int LOG_W = $clog2(VEC_W),
  parameter int IDX_W = LOG_W + 1
) (
  input  logic [IDX_W-1:0] low_mask,
  input  logic [IDX_W-1:0] shamt,
  input  logic [VEC_W-1:0] a,
  output logic [VEC_W-1:0] y
);
  always_comb begin
    logic [IDX_W:0]   reach;
    logic [IDX_W:0]   width;
    logic [IDX_W-1:0] src;
    width = {1'b0, low_mask} + {{IDX_W{1'b0}}, 1'b1};
    for (int i = 0; i < VEC_W; i++) begin
      reach = {1'b0, IDX_W'(i) & low_mask} + {1'b0, shamt};
      src   = IDX_W'(i) + shamt;
      y[i]  = (reach < width) ? a[src[LOG_W-1:0]] : 1'b0;
    end
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int VEC_W  = 128,
  localparam int LOG_W  = $clog2(VEC_W),
  localparam int IDX_W  = LOG_W + 1,
  localparam int WSEL_W = $clog2(LOG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic [IDX_W-1:0]  shift_amt,
  input  logic [VEC_W-1:0]  opnd_a,
  input  logic [VEC_W-1:0]  opnd_b,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result
);
  logic [IDX_W-1:0] low_mask;
  logic [VEC_W-1:0] lane_start;
  logic [VEC_W-1:0] arith_y;
  logic [VEC_W-1:0] shift_y;
  logic [VEC_W-1:0] result_d;
  logic             valid_q;
  logic [VEC_W-1:0] result_q;

  lane_mask_gen #(.VEC_W(VEC_W)) u_mask (
    .width_sel (width_sel),
    .low_mask  (low_mask),
    .lane_start(lane_start)
  );

  lane_addsub #(.VEC_W(VEC_W)) u_addsub (
    .sub       (op_sel == OP_SUB),
    .lane_start(lane_start),
    .a         (opnd_a),
    .b         (opnd_b),
    .sum       (arith_y)
  );

  lane_shifter #(.VEC_W(VEC_W)) u_shift (
    .low_mask(low_mask),
    .shamt   (shift_amt),
    .a       (opnd_a),
    .y       (shift_y)
  );

  // next-state selection
  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: result_d = arith_y;
      OP_AND:         result_d = opnd_a & opnd_b;
      OP_OR:          result_d = opnd_a | opnd_b;
      OP_XOR:         result_d = opnd_a ^ opnd_b;
      OP_SRL:         result_d = shift_y;
      default:        result_d = '0;
    endcase
  end

  // registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= result_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  // R1
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(lane_start) == (VEC_W >> width_sel)));

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R7
  bit_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == '0 && (op_sel == OP_ADD || op_sel == OP_SUB))
      |=> (result == $past(opnd_a ^ opnd_b)));

  // R6
  over_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_SRL && ({1'b0, shift_amt} > {1'b0, low_mask}))
      |=> (result == '0));

  // R10
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[2:1] == 2'b11) |=> (result == '0));
endmodule

// File: tb/lane_alu_tb.sv
module lane_alu_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op_sel;
  logic [2:0]   width_sel;
  logic [7:0]   shift_amt;
  logic [127:0] opnd_a;
  logic [127:0] opnd_b;
  logic         out_valid;
  logic [127:0] result;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;

  lane_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .width_sel(width_sel), .shift_amt(shift_amt), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] ref_op(int op, int k, int sh,
                                          logic [127:0] a, logic [127:0] b);
    int n;
    logic [127:0] m, r, aa, bb, rr;
    n = 1 << k;
    m = (n == 128) ? '1 : ((128'd1 << n) - 128'd1);
    r = '0;
    for (int l = 0; l < 128 / n; l++) begin
      aa = (a >> (l * n)) & m;
      bb = (b >> (l * n)) & m;
      case (op)
        0: rr = aa + bb;
        1: rr = aa - bb;
        2: rr = aa & bb;
        3: rr = aa | bb;
        4: rr = aa ^ bb;
        5: rr = (sh >= n) ? '0 : (aa >> sh);
        default: rr = '0;
      endcase
      r |= (rr & m) << (l * n);
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] lane_ones(int k);
    logic [127:0] v = '0;
    for (int i = 0; i < 128; i += (1 << k)) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register stage)
  task automatic run(string req, int op, int k, int sh,
                     logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    in_valid  = 1'b1;
    op_sel    = 3'(op);
    width_sel = 3'(k);
    shift_amt = 8'(sh);
    opnd_a    = a;
    opnd_b    = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
    chk(req, result, ref_op(op, k, sh, a, b));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; op_sel = 3'd0; width_sel = 3'd3;
    shift_amt = '0; opnd_a = '1; opnd_b = '1;
    repeat (3) @(negedge clk);
    chk("R9 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R9 result", result, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_carry_chain();
    for (int k = 0; k < 8; k++) begin
      run("R2 carry kill", 0, k, 0, '1, lane_ones(k));
      run("R3 borrow kill", 1, k, 0, '0, lane_ones(k));
      run("R1 R2 full add", 0, k, 0, '1, '1);
    end
  endtask

  task automatic t_logic();
    for (int k = 0; k < 8; k++)
      for (int op = 2; op <= 4; op++)
        run("R4 logic", op, k, 0, rnd128(), rnd128());
  endtask

  task automatic t_shift();
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < (1 << k); s += (k > 2 ? 3 : 1))
        run("R5 shift", 5, k, s, rnd128(), rnd128());
      run("R5 shift top", 5, k, (1 << k) - 1, '1, '0);
      run("R6 shift eq", 5, k, 1 << k, '1, '0);
      run("R6 shift big", 5, k, 255, '1, '0);
    end
  endtask

  task automatic t_one_bit();
    logic [127:0] a, b;
    for (int r = 0; r < 4; r++) begin
      a = rnd128(); b = rnd128();
      run("R7 add", 0, 0, 0, a, b);
      chk("R7 add xor", result, a ^ b);
      run("R7 sub", 1, 0, 0, a, b);
      chk("R7 sub xor", result, a ^ b);
    end
  endtask

  task automatic t_random();
    for (int r = 0; r < 6; r++)
      for (int k = 0; k < 8; k++) begin
        run("R2 random add", 0, k, 0, rnd128(), rnd128());
        run("R3 random sub", 1, k, 0, rnd128(), rnd128());
        run("R1 random shift", 5, k, int'($urandom_range(0, 140)), rnd128(), rnd128());
      end
  endtask

  task automatic t_undef();
    run("R10 op6", 6, 3, 0, '1, '1);
    run("R10 op7", 7, 5, 0, '1, '1);
  endtask

  task automatic t_hold();
    logic [127:0] keep;
    run("R8 load", 4, 4, 0, 128'h1234, 128'h00ff);
    keep = result;
    for (int c = 0; c < 3; c++) begin
      opnd_a = rnd128(); opnd_b = rnd128(); op_sel = 3'd3;
      @(negedge clk);
      chk("R8 idle valid", {127'd0, out_valid}, 128'd0);
      chk("R8 idle hold", result, keep);
    end
  endtask

  initial begin
    t_reset();
    t_carry_chain();
    t_logic();
    t_shift();
    t_one_bit();
    t_random();
    t_undef();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule